// File: doc/BRIEF.md
# Low-Power Off State Sequencer

This block is the power-control state machine that takes a system from full operation down into one of two retention "off" states after software asks for it, and then brings it back up when a turn-on event arrives. Software sets a request bit through a small register write port. The sequencer then gives the processor a grace period, measured in ticks of the 32 kHz clock, to wind down its tasks. When that period ends, a warm-start enable bit selects the next state. One choice is a memory-hold state, where only the regulators marked for memory retention stay up. The other is a core-retention state, where the processor reset stays released so that the core state survives.

In both off states the block pulls the system reset low and forces the linear-regulator enables off. It sets each switching-regulator enable from a per-state retention mask and sets the two 32 kHz clock enables according to the configuration bits. No timer runs in either off state. A turn-on pulse leaves memory-hold through a one-cycle cold start, which raises an interrupt flag. It leaves core-retention through a one-cycle warm start. Both exits reload the configuration registers to their power-up defaults, and neither exit switches off a regulator that was kept alive. A watchdog-good input forces a cold start when it drops during full operation, and it is ignored during the wait.

The current state code is visible on a status output, and the interrupt flag is cleared by writing a one to it.

Top module: `lpoff_seq`

## Requirements
- R1: After reset the state code is 0 (fully on). Both resets are high, both 32 kHz clock enables are high, every switching and linear regulator enable is high, and the interrupt flag is 0.
- R2: A write with address 0 and data bit 0 set, made while fully on, moves the state to code 1 (wait) one clock after the register updates. In the wait state all outputs keep their fully-on values.
- R3: In the wait state the watchdog-good input has no effect. While fully on, a low watchdog-good input moves the state to code 4 (cold start), and every switching regulator stays enabled during that cold start.
- R4: The wait state lasts exactly WAIT_TICKS pulses of the 32 kHz tick input, counting ticks and not clock cycles. It then moves to code 3 (core retention) if the warm-start bit (address 0, bit 1) is set, and to code 2 (memory hold) otherwise.
- R5: The request bit is cleared when the wait state ends. After a full off/on cycle the sequencer stays fully on until a new request is written.
- R6: In memory hold, both resets and the peripheral clock enable are low. The processor clock enable follows the retention-clock override bit (address 0, bit 4). All linear-regulator enables are low.
- R7: In core retention, the system reset is low and the processor reset is high. The peripheral clock enable is low. The processor clock enable is (address 0 bit 2 AND address 0 bit 3) OR address 0 bit 4. All linear-regulator enables are low.
- R8: Switching-regulator enable bit i equals bit i of the hold mask (address 1) in memory hold, and bit i of the retention mask (address 2) in core retention.
- R9: A turn-on pulse in memory hold gives state code 4 for one cycle and then code 0. It sets the interrupt flag. During code 4 the regulator enables equal the hold mask. All configuration registers reload to zero.
- R10: A turn-on pulse in core retention gives state code 5 (warm start) for one cycle and then code 0. During code 5 the processor reset is high and the regulator enables equal the retention mask. The interrupt flag is unchanged.
- R11: A turn-on pulse is ignored in the fully-on and wait states. Without a turn-on pulse, both off states hold indefinitely whatever the tick input does.
- R12: Writing address 3 with data bit 0 set clears the interrupt flag, and writing 0 there leaves it unchanged. If a set and a clear arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 hold mask, 2 retention mask, 3 flag clear) |
| wr_data | input | DATA_W | Register write data |
| wdog_ok | input | 1 | Watchdog-good level; low while fully on forces a cold start |
| tick_32k | input | 1 | One-cycle pulse per 32 kHz period |
| turn_on | input | 1 | Synchronized one-cycle turn-on event |
| sys_rst_n | output | 1 | System reset, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| clk32_per_en | output | 1 | Peripheral 32 kHz clock enable |
| clk32_cpu_en | output | 1 | Processor 32 kHz clock enable |
| sw_en | output | N_SW | Switching-regulator enables |
| ldo_en | output | N_LDO | Linear-regulator and block enables |
| state_o | output | 3 | Current state code |
| memhold_irq | output | 1 | Flag set on leaving memory hold |

## Verification
The main shutdown path is run with a table of configurations that cover both warm-start settings, every combination of the clock-keeping bits that matters, and regulator masks that differ between the two off states. Differing masks show whether the right mask drives the outputs in each off state, and whether the same mask is carried through the start state. The clock-bit patterns separate the AND term from the override term in the core-retention clock rule. Directed runs stop the tick input partway through the wait to tell tick counting from cycle counting. They also pulse the watchdog and turn-on inputs in states where these must be ignored. They run a second request without reprogramming, to show that the defaults were reloaded.

// File: rtl/lpoff_pkg.sv
// Package: shared state codes, register addresses and control-bit positions
// for the low-power off sequencer. The state code is exposed on a port, so
// its values are fixed.
package lpoff_pkg;

    typedef enum logic [2:0] {
        LP_ON       = 3'd0,
        LP_WAIT     = 3'd1,
        LP_MEMHOLD  = 3'd2,
        LP_COREKEEP = 3'd3,
        LP_COLD     = 3'd4,
        LP_WARM     = 3'd5
    } lp_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_HOLD = 2'd1;
    localparam logic [1:0] ADDR_RET  = 2'd2;
    localparam logic [1:0] ADDR_IRQ  = 2'd3;

    localparam int CTL_REQ   = 0;
    localparam int CTL_WARM  = 1;
    localparam int CTL_PCLK  = 2;
    localparam int CTL_UOCLK = 3;
    localparam int CTL_DRM   = 4;

endpackage

// File: rtl/lpoff_cfg_regs.sv
// Module: configuration registers and interrupt flag.
// Holds the request, warm-start and clock bits plus the two regulator masks.
// Assumes N_SW <= DATA_W and DATA_W > CTL_DRM. A reload (start state entry)
// returns every register to zero. The request bit also clears when the wait
// state ends. The flag is set by the sequencer and cleared by writing 1.
module lpoff_cfg_regs
    import lpoff_pkg::*;
#(
    parameter int N_SW   = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_req,
    input  logic              reload,
    input  logic              irq_set,
    output logic              req,
    output logic              warm_en,
    output logic              pclk_en,
    output logic              uo_clk,
    output logic              drm,
    output logic [N_SW-1:0]   hold_mask,
    output logic [N_SW-1:0]   ret_mask,
    output logic              irq
);

    logic wr_ctrl, wr_hold, wr_ret, wr_irq;
    logic unused_wr_bits;

    assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_hold = wr_en && (wr_addr == ADDR_HOLD);
    assign wr_ret  = wr_en && (wr_addr == ADDR_RET);
    assign wr_irq  = wr_en && (wr_addr == ADDR_IRQ) && wr_data[0];
    assign unused_wr_bits = ^wr_data;

    // Control bits: reload beats clear, clear beats a write.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            req     <= 1'b0;
            warm_en <= 1'b0;
            pclk_en <= 1'b0;
            uo_clk  <= 1'b0;
            drm     <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                warm_en <= wr_data[CTL_WARM];
                pclk_en <= wr_data[CTL_PCLK];
                uo_clk  <= wr_data[CTL_UOCLK];
                drm     <= wr_data[CTL_DRM];
            end
            if (clr_req)
                req <= 1'b0;
            else if (wr_ctrl)
                req <= wr_data[CTL_REQ];
        end
    end

    // Regulator retention masks for the two off states.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            hold_mask <= '0;
            ret_mask  <= '0;
        end else begin
            if (wr_hold) hold_mask <= wr_data[N_SW-1:0];
            if (wr_ret)  ret_mask  <= wr_data[N_SW-1:0];
        end
    end

    // Interrupt flag: set wins over a same-cycle write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (irq_set)
            irq <= 1'b1;
        else if (wr_irq)
            irq <= 1'b0;
    end

    assert_req_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !req);
    assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> irq);
    assert_irq_w1c_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_irq && !irq_set) |=> !irq);
    assert_irq_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_set && !wr_irq) |=> (irq == $past(irq)));

endmodule

// File: rtl/lpoff_wait_timer.sv
// Module: grace-period timer for the wait state.
// Counts 32 kHz tick pulses while run is high and raises expire in the cycle
// that carries the WAIT_TICKS-th tick. The count is cleared whenever run is
// low. Assumes WAIT_TICKS >= 1.
module lpoff_wait_timer #(
    parameter int WAIT_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);

    localparam int CNT_W = $clog2(WAIT_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    assign expire = run && tick && (cnt == LAST);

    // Tick counter, held at zero outside the wait state.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (tick && !expire)
            cnt <= cnt + 1'b1;
    end

    assert_tick_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (!run || (cnt == $past(cnt))));
    assert_expire_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> run);

endmodule

// File: rtl/lpoff_fsm.sv
// Module: sequencer state register and transition logic.
// Moves through on -> wait -> (memory hold | core retention) -> start -> on.
// When a start state is entered it also records which regulators were alive,
// so they stay on through the start cycle. Assumes turn_on is already a
// synchronized single-cycle pulse.
module lpoff_fsm
    import lpoff_pkg::*;
#(
    parameter int N_SW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            warm_en,
    input  logic            wdog_ok,
    input  logic            expire,
    input  logic            turn_on,
    input  logic [N_SW-1:0] hold_mask,
    input  logic [N_SW-1:0] ret_mask,
    output lp_state_e       state,
    output logic            in_wait,
    output logic            leave_wait,
    output logic            start,
    output logic            irq_set,
    output logic [N_SW-1:0] keep_mask
);

    lp_state_e state_n;
    logic      in_off;

    // Next-state selection.
    always_comb begin
        state_n = state;
        case (state)
            LP_ON:       if (!wdog_ok) state_n = LP_COLD;
                         else if (req) state_n = LP_WAIT;
            LP_WAIT:     if (expire)   state_n = warm_en ? LP_COREKEEP : LP_MEMHOLD;
            LP_MEMHOLD:  if (turn_on)  state_n = LP_COLD;
            LP_COREKEEP: if (turn_on)  state_n = LP_WARM;
            LP_COLD:     state_n = LP_ON;
            LP_WARM:     state_n = LP_ON;
            default:     state_n = LP_ON;
        endcase
    end

    assign in_wait    = (state == LP_WAIT);
    assign in_off     = (state == LP_MEMHOLD) || (state == LP_COREKEEP);
    assign leave_wait = in_wait && expire;
    assign start      = (state_n == LP_COLD) || (state_n == LP_WARM);
    assign irq_set    = (state == LP_MEMHOLD) && turn_on;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LP_ON;
        else        state <= state_n;
    end

    // Snapshot of the regulators to keep alive through the start cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            keep_mask <= '1;
        else if (start)
            keep_mask <= (state == LP_MEMHOLD)  ? hold_mask :
                         (state == LP_COREKEEP) ? ret_mask  : '1;
    end

    assert_enter_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LP_ON && req && wdog_ok) |=> (state == LP_WAIT));
    assert_wait_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LP_WAIT && !expire) |=> (state == LP_WAIT));
    assert_to_corekeep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LP_WAIT && expire && warm_en) |=> (state == LP_COREKEEP));
    assert_to_memhold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LP_WAIT && expire && !warm_en) |=> (state == LP_MEMHOLD));
    assert_off_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_off && !turn_on) |=> $stable(state));
    assert_cold_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LP_MEMHOLD && turn_on) |=> (state == LP_COLD));
    assert_warm_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LP_COREKEEP && turn_on) |=> (state == LP_WARM));
    assert_start_short_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LP_COLD || state == LP_WARM) |=> (state == LP_ON));

endmodule

// File: rtl/lpoff_out_decode.sv
// Module: maps the state and configuration onto resets, clock enables and
// regulator enables. Purely combinational. Off and start states force the
// linear regulators low.
module lpoff_out_decode
    import lpoff_pkg::*;
#(
    parameter int N_SW  = 5,
    parameter int N_LDO = 4
) (
    input  lp_state_e        state,
    input  logic             pclk_en,
    input  logic             uo_clk,
    input  logic             drm,
    input  logic [N_SW-1:0]  hold_mask,
    input  logic [N_SW-1:0]  ret_mask,
    input  logic [N_SW-1:0]  keep_mask,
    output logic             sys_rst_n,
    output logic             cpu_rst_n,
    output logic             clk32_per_en,
    output logic             clk32_cpu_en,
    output logic [N_SW-1:0]  sw_en,
    output logic [N_LDO-1:0] ldo_en
);

    // Output levels per state; fully on and wait share the default.
    always_comb begin
        sys_rst_n    = 1'b1;
        cpu_rst_n    = 1'b1;
        clk32_per_en = 1'b1;
        clk32_cpu_en = 1'b1;
        sw_en        = '1;
        ldo_en       = '1;
        case (state)
            LP_MEMHOLD: begin
                sys_rst_n    = 1'b0;
                cpu_rst_n    = 1'b0;
                clk32_per_en = 1'b0;
                clk32_cpu_en = drm;
                sw_en        = hold_mask;
                ldo_en       = '0;
            end
            LP_COREKEEP: begin
                sys_rst_n    = 1'b0;
                clk32_per_en = 1'b0;
                clk32_cpu_en = (pclk_en && uo_clk) || drm;
                sw_en        = ret_mask;
                ldo_en       = '0;
            end
            LP_COLD: begin
                sys_rst_n    = 1'b0;
                cpu_rst_n    = 1'b0;
                clk32_per_en = 1'b0;
                clk32_cpu_en = 1'b0;
                sw_en        = keep_mask;
                ldo_en       = '0;
            end
            LP_WARM: begin
                sys_rst_n    = 1'b0;
                clk32_per_en = 1'b0;
                sw_en        = keep_mask;
                ldo_en       = '0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lpoff_seq.sv
// Module: top of the low-power off sequencer.
// Connects the register block, the wait timer, the state machine and the
// output decoder. Assumes all inputs are synchronous to clk and that
// tick_32k and turn_on are single-cycle pulses.
module lpoff_seq
    import lpoff_pkg::*;
#(
    parameter int N_SW       = 5,
    parameter int N_LDO      = 4,
    parameter int DATA_W     = 8,
    parameter int WAIT_TICKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wdog_ok,
    input  logic              tick_32k,
    input  logic              turn_on,
    output logic              sys_rst_n,
    output logic              cpu_rst_n,
    output logic              clk32_per_en,
    output logic              clk32_cpu_en,
    output logic [N_SW-1:0]   sw_en,
    output logic [N_LDO-1:0]  ldo_en,
    output logic [2:0]        state_o,
    output logic              memhold_irq
);

    lp_state_e       state;
    logic            req, warm_en, pclk_en, uo_clk, drm;
    logic [N_SW-1:0] hold_mask, ret_mask, keep_mask;
    logic            in_wait, leave_wait, start, irq_set, expire;

    lpoff_cfg_regs #(.N_SW(N_SW), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clr_req(leave_wait), .reload(start),
        .irq_set(irq_set), .req(req), .warm_en(warm_en), .pclk_en(pclk_en),
        .uo_clk(uo_clk), .drm(drm), .hold_mask(hold_mask),
        .ret_mask(ret_mask), .irq(memhold_irq)
    );

    lpoff_wait_timer #(.WAIT_TICKS(WAIT_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(in_wait), .tick(tick_32k),
        .expire(expire)
    );

    lpoff_fsm #(.N_SW(N_SW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .warm_en(warm_en),
        .wdog_ok(wdog_ok), .expire(expire), .turn_on(turn_on),
        .hold_mask(hold_mask), .ret_mask(ret_mask), .state(state),
        .in_wait(in_wait), .leave_wait(leave_wait), .start(start),
        .irq_set(irq_set), .keep_mask(keep_mask)
    );

    lpoff_out_decode #(.N_SW(N_SW), .N_LDO(N_LDO)) u_dec (
        .state(state), .pclk_en(pclk_en), .uo_clk(uo_clk), .drm(drm),
        .hold_mask(hold_mask), .ret_mask(ret_mask), .keep_mask(keep_mask),
        .sys_rst_n(sys_rst_n), .cpu_rst_n(cpu_rst_n),
        .clk32_per_en(clk32_per_en), .clk32_cpu_en(clk32_cpu_en),
        .sw_en(sw_en), .ldo_en(ldo_en)
    );

    assign state_o = state;

    assert_start_keeps_sw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LP_MEMHOLD && turn_on) |=> (sw_en == $past(hold_mask)));
    assert_warm_keeps_sw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LP_COREKEEP && turn_on) |=> (sw_en == $past(ret_mask) && cpu_rst_n));

endmodule

// File: tb/lpoff_seq_bench.sv
module lpoff_seq_bench;

    localparam int N_SW  = 5;
    localparam int N_LDO = 4;
    localparam int DW    = 8;
    localparam int WT    = 3;

    typedef struct packed {
        logic       warm;
        logic       drm;
        logic       pclk;
        logic       uoclk;
        logic [4:0] hold;
        logic [4:0] ret;
        logic [2:0] exp_state;
        logic       exp_cpu_rst;
        logic       exp_cpu_clk;
        logic [4:0] exp_sw;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 5'b00010, 5'b11111, 3'd2, 1'b0, 1'b0, 5'b00010},
        '{1'b0, 1'b1, 1'b0, 1'b0, 5'b10001, 5'b00000, 3'd2, 1'b0, 1'b1, 5'b10001},
        '{1'b1, 1'b0, 1'b1, 1'b1, 5'b11111, 5'b01011, 3'd3, 1'b1, 1'b1, 5'b01011},
        '{1'b1, 1'b0, 1'b1, 1'b0, 5'b00000, 5'b00100, 3'd3, 1'b1, 1'b0, 5'b00100},
        '{1'b1, 1'b0, 1'b0, 1'b1, 5'b00000, 5'b00000, 3'd3, 1'b1, 1'b0, 5'b00000},
        '{1'b1, 1'b1, 1'b0, 1'b0, 5'b00000, 5'b11000, 3'd3, 1'b1, 1'b1, 5'b11000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wdog_ok = 1'b1;
    logic          tick_32k = 1'b0;
    logic          turn_on = 1'b0;
    logic          sys_rst_n, cpu_rst_n, clk32_per_en, clk32_cpu_en;
    logic [N_SW-1:0]  sw_en;
    logic [N_LDO-1:0] ldo_en;
    logic [2:0]    state_o;
    logic          memhold_irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    lpoff_seq #(.N_SW(N_SW), .N_LDO(N_LDO), .DATA_W(DW), .WAIT_TICKS(WT)) u_lpoff_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wdog_ok(wdog_ok), .tick_32k(tick_32k),
        .turn_on(turn_on), .sys_rst_n(sys_rst_n), .cpu_rst_n(cpu_rst_n),
        .clk32_per_en(clk32_per_en), .clk32_cpu_en(clk32_cpu_en),
        .sw_en(sw_en), .ldo_en(ldo_en), .state_o(state_o),
        .memhold_irq(memhold_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_on();
        @(negedge clk);
        turn_on = 1'b1;
        @(negedge clk);
        turn_on = 1'b0;
    endtask

    task automatic wait_off();
        for (int i = 0; i < 40; i++) begin
            if (state_o == 3'd2 || state_o == 3'd3) break;
            @(negedge clk);
        end
    endtask

    task automatic chk_on(input string tag);
        chk({tag, " state"}, 32'(state_o), 32'd0);
        chk({tag, " resets"}, {30'd0, sys_rst_n, cpu_rst_n}, 32'd3);
        chk({tag, " clocks"}, {30'd0, clk32_per_en, clk32_cpu_en}, 32'd3);
        chk({tag, " sw"}, 32'(sw_en), 32'h1f);
        chk({tag, " ldo"}, 32'(ldo_en), 32'hf);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_on("R1 reset");
        chk("R1 irq", 32'(memhold_irq), 32'd0);

        // Table walk: R4 R6 R7 R8 R9 R10
        tick_32k = 1'b1;
        foreach (VECS[k]) begin
            wr(2'd1, DW'(VECS[k].hold));
            wr(2'd2, DW'(VECS[k].ret));
            wr(2'd0, DW'({VECS[k].drm, VECS[k].uoclk, VECS[k].pclk, VECS[k].warm, 1'b1}));
            wait_off();
            chk("R4 off state", 32'(state_o), 32'(VECS[k].exp_state));
            chk("R6_R7 sys reset", 32'(sys_rst_n), 32'd0);
            chk("R6_R7 cpu reset", 32'(cpu_rst_n), 32'(VECS[k].exp_cpu_rst));
            chk("R6_R7 per clk", 32'(clk32_per_en), 32'd0);
            chk("R6_R7 cpu clk", 32'(clk32_cpu_en), 32'(VECS[k].exp_cpu_clk));
            chk("R8 sw", 32'(sw_en), 32'(VECS[k].exp_sw));
            chk("R6_R7 ldo", 32'(ldo_en), 32'd0);
            repeat (6) @(negedge clk);
            chk("R11 off holds", 32'(state_o), 32'(VECS[k].exp_state));
            pulse_on();
            if (VECS[k].warm) begin
                chk("R10 warm state", 32'(state_o), 32'd5);
                chk("R10 cpu reset", 32'(cpu_rst_n), 32'd1);
                chk("R10 sw kept", 32'(sw_en), 32'(VECS[k].exp_sw));
                chk("R10 irq", 32'(memhold_irq), 32'd0);
            end else begin
                chk("R9 cold state", 32'(state_o), 32'd4);
                chk("R9 sw kept", 32'(sw_en), 32'(VECS[k].exp_sw));
                chk("R9 irq", 32'(memhold_irq), 32'd1);
            end
            @(negedge clk);
            chk_on("R9_R10 back on");
            if (!VECS[k].warm) begin
                wr(2'd3, 8'h01);
                chk("R12 clear", 32'(memhold_irq), 32'd0);
            end
        end

        // R5: stays on with no new request
        repeat (10) @(negedge clk);
        chk("R5 stays on", 32'(state_o), 32'd0);

        // R9: defaults reloaded -> bare request goes to memory hold, masks zero
        wr(2'd0, 8'h01);
        wait_off();
        chk("R9 reload state", 32'(state_o), 32'd2);
        chk("R9 reload sw", 32'(sw_en), 32'd0);
        chk("R9 reload cpu clk", 32'(clk32_cpu_en), 32'd0);

        // R12: set and clear in the same cycle -> set wins
        @(negedge clk);
        turn_on = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01;
        @(negedge clk);
        turn_on = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R12 set wins", 32'(memhold_irq), 32'd1);
        wr(2'd3, 8'h00);
        chk("R12 write zero", 32'(memhold_irq), 32'd1);
        wr(2'd3, 8'h01);
        chk("R12 write one", 32'(memhold_irq), 32'd0);
        chk_on("R9 after cold");

        // R11: turn-on ignored when fully on
        pulse_on();
        chk("R11 ignore in on", 32'(state_o), 32'd0);

        // R2, R3, R4: wait state with ticks held off
        tick_32k = 1'b0;
        wr(2'd0, 8'h01);
        @(negedge clk);
        chk("R2 wait state", 32'(state_o), 32'd1);
        chk("R2 sys reset", 32'(sys_rst_n), 32'd1);
        chk("R2 sw", 32'(sw_en), 32'h1f);
        wdog_ok = 1'b0;
        pulse_on();
        chk("R11 ignore in wait", 32'(state_o), 32'd1);
        repeat (8) @(negedge clk);
        chk("R3 wdog ignored", 32'(state_o), 32'd1);
        chk("R4 no ticks", 32'(state_o), 32'd1);
        wdog_ok = 1'b1;
        tick_32k = 1'b1;
        begin
            int n;
            n = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                n++;
                if (state_o != 3'd1) break;
            end
            chk("R4 tick count", 32'(n), 32'(WT));
        end
        chk("R4 memhold", 32'(state_o), 32'd2);
        tick_32k = 1'b0;
        repeat (5) @(negedge clk);
        chk("R11 no ticks off", 32'(state_o), 32'd2);
        pulse_on();
        @(negedge clk);
        wr(2'd3, 8'h01);

        // R3: watchdog low while fully on -> cold start
        @(negedge clk);
        wdog_ok = 1'b0;
        @(negedge clk);
        wdog_ok = 1'b1;
        chk("R3 wdog cold", 32'(state_o), 32'd4);
        chk("R3 wdog sw", 32'(sw_en), 32'h1f);
        @(negedge clk);
        chk("R3 back on", 32'(state_o), 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule